// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block connects a converter core to a three-wire serial audio link made of a bit clock, a frame clock and a data line. The receive side turns the serial input into parallel samples. Each sample comes with a one-cycle strobe and a channel index. The transmit side shifts out a left and a right sample on the same link. Five framings are available:

- I2S
- left-justified
- right-justified
- DSP, with a short frame pulse at twice the sample rate
- packed TDM, with 256 bit clocks per frame carrying eight 32-bit slots

All logic runs on one system clock that oversamples the link. In slave mode the bit clock and frame clock come in on pins and pass through a two-flop synchronizer, together with the data. In master mode the port divides its system clock to make both clocks, drives them out, and uses them internally through the same synchronizer path.

Received words are MSB-justified in a 24-bit bus. Word widths of 16, 20 and 24 bits are selectable.

Top module: `audio_serial_port`

## Requirements
- R1: With `master`=1, `bclk_out` has a period of 2*HALF clock cycles. `lrclk_out` changes only when `bclk_out` falls. The frame clock depends on `fmt`:
  - stereo formats: square wave of 64 bit clocks per frame, low first.
  - DSP: high for 1 bit clock in every 32.
  - TDM: 256 bit clocks per frame, low for the first 128.
- R2: I2S (`fmt`=0, and codes 5 to 7): a word's MSB is the bit sampled one bit clock after a frame-clock edge. Frame clock low marks left (channel 0) and high marks right (channel 1).
- R3: Left-justified (`fmt`=1): the MSB is the bit sampled on the first rising bit-clock edge after a frame-clock change.
- R4: Right-justified (`fmt`=2): the received word is the last W bits sampled before a frame-clock edge. It is reported at that edge, with the channel the frame clock showed before the edge.
- R5: DSP (`fmt`=3): only rising frame-clock edges start a word, and the MSB follows one bit clock later. Words alternate left then right, starting with left after reset. The frame-clock level never selects the channel.
- R6: TDM (`fmt`=4): the frame clock falls at frame start. Each slot takes its first W bits, MSB first. The first three slots of the low half give channels 0, 2 and 4, and the first three slots of the high half give channels 1, 3 and 5, i.e. `rx_chan` = 2*pair + right. The fourth slot of each half produces no strobe.
- R7: `wlen` 0 selects 24 bits, 1 selects 20, 2 selects 16 and 3 selects 24. `rx_data` carries the word in its top W bits, with the lower bits zero.
- R8: `rx_valid` is a single-cycle pulse that comes with `rx_data` and `rx_chan`. No word is reported before the first qualifying frame-clock edge after reset.
- R9: `sdout` changes only after a falling bit-clock edge. It carries the top W bits of `tx_left` (left) or `tx_right` (right), MSB first, using the same framing positions as receive. All bits outside a word are 0.
- R10: Right-justified transmit places the word so that its LSB is bit 31 of each 32-bit-clock half frame.
- R11: TDM transmit puts `tx_left` in the first slot and `tx_right` in the fifth slot. All other slots are zero.
- R12: In the stereo formats the receiver accepts half frames longer than 32 bit clocks (burst clocking).
- R13: While reset is asserted, `rx_valid`, `rx_data`, `sdout` and `bclk_out` are 0. An all-zero `fmt`/`wlen` selection means I2S with 24-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate the link clocks; 0: take them from the pins |
| fmt | input | 3 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP, 4 TDM |
| wlen | input | 2 | Word width code: 0 24, 1 20, 2 16, 3 24 |
| bclk_in | input | 1 | Bit clock from the link in slave mode |
| lrclk_in | input | 1 | Frame clock from the link in slave mode |
| sdin | input | 1 | Serial receive data |
| tx_left | input | 24 | Left sample to transmit |
| tx_right | input | 24 | Right sample to transmit |
| bclk_out | output | 1 | Generated bit clock (master) |
| lrclk_out | output | 1 | Generated frame clock (master) |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | 24 | Received word, MSB-justified |
| rx_chan | output | 3 | Channel index of the received word |
| rx_valid | output | 1 | One-cycle strobe for a received word |

## Verification
The assertions assume the following about the inputs:
- `fmt`, `wlen` and `master` are held steady outside reset.
- In slave mode, each bit-clock phase lasts at least four system clocks.
- The frame clock and data change together with the falling bit-clock edge.

The bench changes the configuration only while reset is asserted. It drives the link with a six-cycle bit-clock phase and sets the frame clock and data in the same cycle as the falling edge. Sample values come from a fixed-seed random source. Burst half frames and the master-mode loopback are the directed corner cases.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int HALF = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic [2:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        bclk_in,
  input  logic        lrclk_in,
  input  logic        sdin,
  input  logic [23:0] tx_left,
  input  logic [23:0] tx_right,
  output logic        bclk_out,
  output logic        lrclk_out,
  output logic        sdout,
  output logic [23:0] rx_data,
  output logic [2:0]  rx_chan,
  output logic        rx_valid
);
  localparam int SW = 24;
  localparam int DW = $clog2(HALF + 1);
  localparam logic [2:0] F_LJ = 3'd1, F_RJ = 3'd2, F_DSP = 3'd3, F_TDM = 3'd4;

  wire dsp = (fmt == F_DSP);
  wire rj  = (fmt == F_RJ);
  wire tdm = (fmt == F_TDM);

  // clock generation for master mode
  logic [DW-1:0] dcnt;
  logic          bgen;
  logic [7:0]    mcnt;
  logic          lrgen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt <= '0; bgen <= 1'b0; mcnt <= '0;
    end else if (master) begin
      if (dcnt == DW'(HALF - 1)) begin
        dcnt <= '0;
        bgen <= ~bgen;
        if (bgen) mcnt <= mcnt + 8'd1;
      end else dcnt <= dcnt + DW'(1);
    end

  always_comb
    case (fmt)
      F_DSP:   lrgen = (mcnt[4:0] == 5'd0);
      F_TDM:   lrgen = mcnt[7];
      default: lrgen = mcnt[5];
    endcase

  assign bclk_out  = bgen;
  assign lrclk_out = master & lrgen;

  // synchronizer and edge detection
  logic [1:0] bs, ls, ds;
  logic       bp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bs <= '0; ls <= 2'b11; ds <= '0; bp <= 1'b0;
    end else begin
      bs <= {bs[0], master ? bgen : bclk_in};
      ls <= {ls[0], master ? lrgen : lrclk_in};
      ds <= {ds[0], sdin};
      bp <= bs[1];
    end

  wire rise = bs[1] & ~bp;
  wire fall = ~bs[1] & bp;
  wire lr   = ls[1];
  wire sd   = ds[1];

  logic [4:0] wid;
  always_comb
    case (wlen)
      2'd1:    wid = 5'd20;
      2'd2:    wid = 5'd16;
      default: wid = 5'd24;
    endcase
  wire [4:0] sa = 5'(SW) - wid;

  function automatic logic [5:0] locate(input logic [2:0] f, input logic [7:0] p, input logic [4:0] w);
    logic [7:0] st, d;
    logic       hit;
    case (f)
      F_LJ:    st = 8'd0;
      F_RJ:    st = 8'd32 - {3'b0, w};
      default: st = 8'd1;
    endcase
    d   = p - st;
    hit = (p >= st) && (d < {3'b0, w});
    if (f == F_TDM) begin
      d   = {3'b0, p[4:0]};
      hit = !p[7] && (p[6:5] != 2'd3) && (p[4:0] < w);
    end
    return {hit, d[4:0]};
  endfunction

  // receive
  logic          lrr, rsync, rtog, rdch;
  logic [7:0]    rpos;
  logic [SW-1:0] sh;
  logic [2:0]    rch;

  wire          redge = dsp ? (lr & ~lrr) : (lr ^ lrr);
  wire [7:0]    rpn   = redge ? 8'd0 : ((rpos == 8'hFF) ? rpos : rpos + 8'd1);
  wire [5:0]    rloc  = locate(fmt, rpn, wid);
  wire          rin   = (rsync | redge) & rloc[5];
  wire [SW-1:0] rword = {sh[SW-2:0], sd};

  always_comb
    if (tdm)      rch = {rpn[6:5], lr};
    else if (dsp) rch = {2'b0, rdch};
    else          rch = {2'b0, lr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lrr <= 1'b1; rsync <= 1'b0; rtog <= 1'b0; rdch <= 1'b0; rpos <= '0; sh <= '0;
      rx_valid <= 1'b0; rx_data <= '0; rx_chan <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        lrr  <= lr;
        rpos <= rpn;
        if (redge) rsync <= 1'b1;
        if (dsp && redge) begin rdch <= rtog; rtog <= ~rtog; end
        if (rj) begin
          sh <= rword;
          if (redge && rsync) begin
            rx_valid <= 1'b1; rx_data <= sh << sa; rx_chan <= {2'b0, lrr};
          end
        end else if (rin) begin
          sh <= rword;
          if (rloc[4:0] == wid - 5'd1) begin
            rx_valid <= 1'b1; rx_data <= rword << sa; rx_chan <= rch;
          end
        end
      end
    end

  // transmit
  logic       lrf, fsync, ftog, fdch;
  logic [7:0] fpos;

  wire          fedge  = dsp ? (lr & ~lrf) : (lr ^ lrf);
  wire [7:0]    fpn    = fedge ? 8'd0 : ((fpos == 8'hFF) ? fpos : fpos + 8'd1);
  wire [5:0]    tloc   = locate(fmt, fpn, wid);
  wire          tright = dsp ? (fedge ? ftog : fdch) : lr;
  wire [SW-1:0] tword  = tright ? tx_right : tx_left;
  wire          tbit   = tword[5'(SW - 1) - tloc[4:0]];
  wire          tact   = (fsync | fedge) & tloc[5] & (!tdm | (fpn[6:5] == 2'd0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lrf <= 1'b1; fsync <= 1'b0; ftog <= 1'b0; fdch <= 1'b0; fpos <= '0; sdout <= 1'b0;
    end else if (fall) begin
      lrf  <= lr;
      fpos <= fpn;
      if (fedge) fsync <= 1'b1;
      if (dsp && fedge) begin fdch <= ftog; ftog <= ~ftog; end
      sdout <= tact ? tbit : 1'b0;
    end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r6_no_spare_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tdm) |-> (rx_chan[2:1] != 2'd3));
  a_r2_stereo_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !tdm) |-> (rx_chan[2:1] == 2'd0));
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && wlen == 2'd2) |-> (rx_data[7:0] == 8'd0));
  a_r9_drive_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(sdout)) |-> !bclk_out);
  a_r1_bclk_hold: assert property (@(posedge clk) disable iff (!rst_n || !master)
    $rose(bclk_out) |=> bclk_out);
endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int HP = 6;
  logic clk = 0, rst_n = 0, master = 0, loop = 0;
  logic [2:0] fmt = 0;
  logic [1:0] wlen = 0;
  logic bclk_i = 0, lr_i = 1, sd_r = 0;
  logic [23:0] tl = 0, tr = 0;
  wire bclk_out, lrclk_out, sdout, rx_valid;
  wire [23:0] rx_data;
  wire [2:0] rx_chan;
  wire sdin = loop ? sdout : sd_r;

  audio_serial_port dut (.clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wlen(wlen),
    .bclk_in(bclk_i), .lrclk_in(lr_i), .sdin(sdin), .tx_left(tl), .tx_right(tr),
    .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdout(sdout),
    .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid));

  always #10 clk = ~clk;

  int total = 0, bad = 0, nr = 0;
  logic [23:0] rd [64];
  logic [2:0]  rc [64];
  logic [23:0] fw [8];

  always @(negedge clk)
    if (rst_n && rx_valid && nr < 64) begin rd[nr] = rx_data; rc[nr] = rx_chan; nr = nr + 1; end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", rq, act, exp); end
  endtask

  function automatic logic [1:0] ser(input int f, input int w, input int hl, input int pos, input bit tx);
    int u, p, st; logic l, d; logic [23:0] wd;
    if (f == 4) begin u = pos / 32; p = pos % 32; l = (pos >= 128); st = 0; end
    else if (f == 3) begin u = pos / 32; p = pos % 32; l = (p == 0); st = 1; end
    else begin u = pos / hl; p = pos % hl; l = (u != 0); st = (f == 0) ? 1 : (f == 1) ? 0 : hl - w; end
    if (tx) wd = (f == 4) ? ((u == 0) ? tl : (u == 4) ? tr : 24'd0) : ((u == 0) ? tl : tr);
    else wd = fw[u];
    d = (p >= st && p - st < w) ? wd[23 - (p - st)] : 1'b0;
    return {l, d};
  endfunction

  function automatic logic [23:0] msk(input logic [23:0] v, input int w);
    return v & (24'hFFFFFF << (24 - w));
  endfunction

  task automatic do_reset(input logic idle);
    rst_n = 0; bclk_i = 0; lr_i = idle; sd_r = 0;
    repeat (4) @(negedge clk);
    nr = 0; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bc(input logic l, input logic d, input logic e, output bit mis);
    bclk_i = 0; lr_i = l; sd_r = d;
    repeat (HP) @(negedge clk);
    mis = (sdout !== e);
    bclk_i = 1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic run_rx(input int f, input int wc, input int hl, input int nfr, input string rq, input string tq);
    int w, flen, ne, txbad; bit mis; logic [1:0] s, e; logic idle;
    logic [23:0] ed [64]; logic [2:0] ec [64];
    w = (wc == 1) ? 20 : (wc == 2) ? 16 : 24;
    flen = (f == 4) ? 256 : (f == 3) ? 64 : 2 * hl;
    idle = (f == 3) ? 1'b0 : 1'b1;
    master = 0; loop = 0; fmt = 3'(f); wlen = 2'(wc);
    tl = 24'($urandom); tr = 24'($urandom);
    do_reset(idle);
    for (int i = 0; i < 4; i++) bc(idle, 1'b1, 1'b0, mis);
    chk(nr == 0, "R8 no word before first frame edge", nr, 0);
    ne = 0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int i = 0; i < 8; i++) fw[i] = 24'($urandom);
      if (f == 4) begin
        for (int u = 0; u < 8; u++)
          if (u != 3 && u != 7) begin
            ed[ne] = msk(fw[u], w); ec[ne] = 3'((u < 4) ? 2 * u : 2 * (u - 4) + 1); ne++;
          end
      end else begin
        ed[ne] = msk(fw[0], w); ec[ne] = 3'd0; ne++;
        ed[ne] = msk(fw[1], w); ec[ne] = 3'd1; ne++;
      end
      txbad = 0;
      for (int pos = 0; pos < flen; pos++) begin
        s = ser(f, w, hl, pos, 0);
        e = ser(f, w, hl, pos, 1);
        bc(s[1], s[0], e[0], mis);
        if (mis) txbad++;
      end
      if (!(f == 2 && hl != 32)) chk(txbad == 0, tq, txbad, 0);
    end
    for (int i = 0; i < 40; i++) bc(1'b0, 1'b0, 1'b0, mis);
    chk(nr >= ne, rq, nr, ne);
    for (int k = 0; k < ne && k < nr; k++)
      chk(rd[k] == ed[k] && rc[k] == ec[k], rq, {5'd0, rc[k], rd[k]}, {5'd0, ec[k], ed[k]});
  endtask

  task automatic meas(input bit uselr, output int per, output int hi);
    logic pv, cv;
    pv = uselr ? lrclk_out : bclk_out;
    cv = pv;
    while (1) begin @(negedge clk); cv = uselr ? lrclk_out : bclk_out; if (cv && !pv) break; pv = cv; end
    per = 0; hi = 0; pv = cv;
    while (1) begin
      @(negedge clk); cv = uselr ? lrclk_out : bclk_out;
      per++; if (cv) hi++;
      if (cv && !pv) break;
      pv = cv;
    end
  endtask

  initial begin
    int per, hi;
    void'($urandom(32'd4711));
    // R13: reset state
    rst_n = 0; master = 1; fmt = 0; wlen = 0;
    repeat (3) @(negedge clk);
    chk(rx_valid == 0 && rx_data == 0, "R13 receive outputs in reset", {rx_valid, rx_data}, 0);
    chk(sdout == 0 && bclk_out == 0, "R13 sdout/bclk_out in reset", {sdout, bclk_out}, 0);

    run_rx(0, 0, 32, 3, "R2 R13 I2S 24-bit default coding", "R9 I2S transmit");
    run_rx(1, 1, 32, 3, "R3 R7 left-justified 20-bit", "R9 left-justified transmit");
    run_rx(2, 2, 32, 3, "R4 R7 right-justified 16-bit", "R10 right-justified transmit 16");
    run_rx(2, 0, 32, 2, "R4 right-justified 24-bit", "R10 right-justified transmit 24");
    run_rx(3, 0, 32, 3, "R5 DSP alternating channels", "R9 DSP transmit");
    run_rx(4, 2, 32, 2, "R6 TDM slot map 16-bit", "R11 TDM transmit 16");
    run_rx(4, 0, 32, 2, "R6 TDM slot map 24-bit", "R11 TDM transmit 24");
    run_rx(1, 0, 40, 2, "R12 burst left-justified", "R12 burst transmit");
    run_rx(2, 1, 40, 2, "R12 burst right-justified", "R12 unused");
    run_rx(0, 3, 48, 2, "R12 R7 burst I2S width code 3", "R12 burst I2S transmit");

    // R1: master clocks, loopback in left-justified mode
    master = 1; loop = 1; fmt = 3'd1; wlen = 2'd0;
    tl = 24'($urandom); tr = 24'($urandom);
    do_reset(1'b1);
    meas(0, per, hi);
    chk(per == 8 && hi == 4, "R1 bit clock period", {per[15:0], hi[15:0]}, {16'd8, 16'd4});
    meas(1, per, hi);
    chk(per == 512 && hi == 256, "R1 stereo frame clock", {per[15:0], hi[15:0]}, {16'd512, 16'd256});
    while (nr < 4) @(negedge clk);
    chk(rd[1] == tr && rc[1] == 3'd1, "R9 R1 master loopback right", {5'd0, rc[1], rd[1]}, {8'd1, tr});
    chk(rd[2] == tl && rc[2] == 3'd0, "R9 R1 master loopback left", {5'd0, rc[2], rd[2]}, {8'd0, tl});
    chk(rd[3] == tr && rc[3] == 3'd1, "R9 R1 master loopback right again", {5'd0, rc[3], rd[3]}, {8'd1, tr});

    fmt = 3'd3; do_reset(1'b0);
    meas(1, per, hi);
    chk(per == 256 && hi == 8, "R1 DSP frame pulse", {per[15:0], hi[15:0]}, {16'd256, 16'd8});
    fmt = 3'd4; do_reset(1'b0);
    meas(1, per, hi);
    chk(per == 2048 && hi == 1024, "R1 TDM frame clock", {per[15:0], hi[15:0]}, {16'd2048, 16'd1024});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule